// File: doc/BRIEF.md
# UART Register File and Interrupt Prioritiser

This block is the register side of a simple 16550-style serial port. A host reaches it over a word-aligned register bus with eight registers. The block keeps one received byte and passes bytes written by the host to a transmit byte stream. It keeps the line-status and modem-status flags and turns the enabled conditions into one prioritised interrupt, with an identification code the host can read.

The serial shifter, the baud generator and the modem pin synchronisers sit outside this block. The divisor, line-control and modem-control values are stored here and exported as outputs. Modem conditions arrive as four level inputs plus four change pulses. The change pulses come from the synchroniser stage.

Top module: `uart_regfile_irq`

## Requirements
- R1: After the synchronous active-high reset, the line status reads 0x60 and the identification register reads 0x01. The interrupt line, the exported control values and `tx_valid` are all zero, and `rx_ready` is high.
- R2: The register index is the byte address shifted right by two: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. Enable, line control, modem control and divisor take writes: line control and modem control are exported from wdata[7:0] and the divisor from wdata[15:0]. Reads of these four return zero.
- R3: Writes to the identification, line-status and modem-status registers change nothing. Any access whose address bits above bit 4 are nonzero is ignored, and a read of it returns zero.
- R4: A received byte (`rx_valid` high for one cycle) is latched and sets data-ready (line status bit 0). `rx_ready` is low while data-ready is set.
- R5: A byte that arrives while data-ready is set, with no data-register read in the same cycle, sets overrun (line status bit 1) and replaces the held byte.
- R6: Read data appears on `rdata` in the cycle after the read strobe. A read of the data register returns the held byte and clears data-ready.
- R7: A write to the data register puts wdata[7:0] on `tx_data` with `tx_valid` high until `tx_ready` accepts it. A write made while an earlier byte is still pending is dropped. Line status bits 6:5 stay set.
- R8: Parity, framing and break flags that come with a byte set line status bits 2, 3 and 4. A line-status read returns the flags and then clears bits 4:1.
- R9: Modem status bits 7:4 follow `modem_lines`. Bits 3:0 are held flags that `modem_delta` pulses set and a modem-status read clears.
- R10: Interrupt enable bits are: 0 received data, 1 transmit holding empty, 2 line error, 3 modem change. The identification code in bits 2:0 is chosen by priority, highest first: an enabled line error (any of status bits 4:1) gives 0b110, enabled data-ready gives 0b100, enabled transmit-empty gives 0b010, an enabled modem flag gives 0b000, and no active source gives 0b001.
- R11: `irq` is high exactly when the identification code is not 0b001. It is updated from register state in the cycle after each access or received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for this byte |
| rx_ferr | input | 1 | Framing error for this byte |
| rx_brk | input | 1 | Break seen with this byte |
| rx_ready | output | 1 | High while no byte is held |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink accepts the pending byte |
| modem_lines | input | 4 | Modem line levels |
| modem_delta | input | 4 | Modem change pulses |
| lcr_out | output | CTRL_W | Stored line control |
| mcr_out | output | CTRL_W | Stored modem control |
| div_out | output | DIV_W | Stored baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps through all sixteen enable settings against every combination of pending line error, data-ready and modem flag, with transmit-empty always set. This catches a design that ranks the sources wrongly or ignores an enable bit; such a design would report the wrong identification code or drive `irq` against the code. It also targets the cases a design could miss without showing it elsewhere: a write made while a byte is still pending, which must not overwrite `tx_data`; a second byte, which must raise overrun; and status reads, which must clear their flags after returning them. It checks accesses outside the window and writes to the read-only registers. A design that aliased addresses or stored these writes would change the exported values or the status that is read back.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   typedef enum logic [2:0] {
      IX_DATA  = 3'd0,
      IX_IEN   = 3'd1,
      IX_IDENT = 3'd2,
      IX_LCTL  = 3'd3,
      IX_MCTL  = 3'd4,
      IX_LSTAT = 3'd5,
      IX_MSTAT = 3'd6,
      IX_DIV   = 3'd7
   } reg_ix_t;

   localparam logic [2:0] ID_LINE  = 3'b110;
   localparam logic [2:0] ID_RXD   = 3'b100;
   localparam logic [2:0] ID_THRE  = 3'b010;
   localparam logic [2:0] ID_MODEM = 3'b000;
   localparam logic [2:0] ID_NONE  = 3'b001;

   localparam int NUM_SRC = 4;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic       rx_perr,
   input  logic       rx_ferr,
   input  logic       rx_brk,
   input  logic       rd_data,
   input  logic       rd_lsr,
   output logic [7:0] held,
   output logic       dready,
   output logic [3:0] errs,
   output logic       rx_ready
);
   logic ovr_evt;

   assign ovr_evt  = rx_valid & dready & ~rd_data;
   assign rx_ready = ~dready;

   always_ff @(posedge clk) begin
      if (rst) begin
         held   <= '0;
         dready <= 1'b0;
         errs   <= '0;
      end else begin
         if (rx_valid) begin
            held   <= rx_data;
            dready <= 1'b1;
         end else if (rd_data) begin
            dready <= 1'b0;
         end
         errs[0] <= (errs[0] & ~rd_lsr) | ovr_evt;
         errs[1] <= (errs[1] & ~rd_lsr) | (rx_valid & rx_perr);
         errs[2] <= (errs[2] & ~rd_lsr) | (rx_valid & rx_ferr);
         errs[3] <= (errs[3] & ~rd_lsr) | (rx_valid & rx_brk);
      end
   end

   // R4
   rx_latch_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> dready && held == $past(rx_data));
   // R5
   overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && dready && !rd_data) |=> errs[0]);
   // R6
   data_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_data && !rx_valid) |=> !dready);
endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_data,
   input  logic [7:0] wbyte,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data
);
   logic slot_free;

   assign slot_free = ~tx_valid | tx_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (wr_data && slot_free) begin
         tx_valid <= 1'b1;
         tx_data  <= wbyte;
      end else if (tx_ready) begin
         tx_valid <= 1'b0;
      end
   end

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));
endmodule

// File: rtl/uart_msr_track.sv
module uart_msr_track (
   input  logic       clk,
   input  logic       rst,
   input  logic [3:0] lines,
   input  logic [3:0] delta,
   input  logic       rd_msr,
   output logic [7:0] msr
);
   logic [3:0] sticky;

   always_ff @(posedge clk) begin
      if (rst) sticky <= '0;
      else     sticky <= (sticky & {4{~rd_msr}}) | delta;
   end

   assign msr = {lines, sticky};

   // R9
   delta_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_msr) |=> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_rf_pkg::*;
(
   input  logic [NUM_SRC-1:0] ien,
   input  logic               line_err,
   input  logic               dready,
   input  logic               thre,
   input  logic               modem_chg,
   output logic [2:0]         ident,
   output logic               irq
);
   // index 0 is the lowest priority, NUM_SRC-1 the highest
   logic [NUM_SRC-1:0] active;
   logic [2:0]         code [NUM_SRC];

   assign active[0] = modem_chg & ien[3];
   assign active[1] = thre      & ien[1];
   assign active[2] = dready    & ien[0];
   assign active[3] = line_err  & ien[2];
   assign code[0]   = ID_MODEM;
   assign code[1]   = ID_THRE;
   assign code[2]   = ID_RXD;
   assign code[3]   = ID_LINE;

   always_comb begin
      ident = ID_NONE;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (active[k]) ident = code[k];
      end
   end

   assign irq = |active;
endmodule

// File: rtl/uart_regfile_irq.sv
module uart_regfile_irq
   import uart_rf_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DIV_W  = 16,
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   input  logic [3:0]        modem_lines,
   input  logic [3:0]        modem_delta,
   output logic [CTRL_W-1:0] lcr_out,
   output logic [CTRL_W-1:0] mcr_out,
   output logic [DIV_W-1:0]  div_out,
   output logic              irq
);
   localparam int IX_LO = 2;
   localparam int IX_HI = 4;

   generate
      if (ADDR_W < IX_HI + 1) begin : g_bad_addr
         $error("ADDR_W must cover eight word registers");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("DIV_W must lie in 1..32");
      end
      if (CTRL_W < 1 || CTRL_W > 32) begin : g_bad_ctrl
         $error("CTRL_W must lie in 1..32");
      end
   endgenerate

   logic    in_win;
   reg_ix_t ix;

   generate
      if (ADDR_W > IX_HI + 1) begin : g_win
         assign in_win = (addr[ADDR_W-1:IX_HI+1] == '0);
      end else begin : g_nowin
         assign in_win = 1'b1;
      end
   endgenerate

   assign ix = reg_ix_t'(addr[IX_HI:IX_LO]);

   logic wr_hit, rd_hit;
   assign wr_hit = wr_en & in_win;
   assign rd_hit = rd_en & in_win;

   logic rd_data_s, rd_lsr_s, rd_msr_s, wr_data_s;
   assign rd_data_s = rd_hit & (ix == IX_DATA);
   assign rd_lsr_s  = rd_hit & (ix == IX_LSTAT);
   assign rd_msr_s  = rd_hit & (ix == IX_MSTAT);
   assign wr_data_s = wr_hit & (ix == IX_DATA);

   logic [NUM_SRC-1:0] ien;

   always_ff @(posedge clk) begin
      if (rst) begin
         ien     <= '0;
         lcr_out <= '0;
         mcr_out <= '0;
         div_out <= '0;
      end else if (wr_hit) begin
         case (ix)
            IX_IEN:  ien     <= wdata[NUM_SRC-1:0];
            IX_LCTL: lcr_out <= wdata[CTRL_W-1:0];
            IX_MCTL: mcr_out <= wdata[CTRL_W-1:0];
            IX_DIV:  div_out <= wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   logic [7:0] held;
   logic       dready;
   logic [3:0] errs;
   logic [7:0] msr;
   logic [2:0] ident;
   logic [7:0] lsr;

   uart_rx_hold u_rx (
      .clk(clk), .rst(rst),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
      .rd_data(rd_data_s), .rd_lsr(rd_lsr_s),
      .held(held), .dready(dready), .errs(errs), .rx_ready(rx_ready)
   );

   uart_tx_stage u_tx (
      .clk(clk), .rst(rst),
      .wr_data(wr_data_s), .wbyte(wdata[7:0]),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
   );

   uart_msr_track u_msr (
      .clk(clk), .rst(rst),
      .lines(modem_lines), .delta(modem_delta),
      .rd_msr(rd_msr_s), .msr(msr)
   );

   // the transmit path hands bytes off directly, so both empty flags stay set
   assign lsr = {1'b0, 1'b1, 1'b1, errs, dready};

   uart_irq_prio u_prio (
      .ien(ien), .line_err(|errs), .dready(dready), .thre(lsr[5]),
      .modem_chg(|msr[3:0]), .ident(ident), .irq(irq)
   );

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (rd_hit) begin
         case (ix)
            IX_DATA:  rd_mux = {24'd0, held};
            IX_IDENT: rd_mux = {29'd0, ident};
            IX_LSTAT: rd_mux = {24'd0, lsr};
            IX_MSTAT: rd_mux = {24'd0, msr};
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) rdata <= '0;
      else     rdata <= rd_mux;
   end

   // R3
   oow_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !in_win) |=> rdata == 32'd0);
   // R2
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && (ix == IX_IEN || ix == IX_LCTL || ix == IX_MCTL || ix == IX_DIV))
      |=> rdata == 32'd0);
   // R10
   line_first_chk: assert property (@(posedge clk) disable iff (rst)
      (|errs && ien[2]) |-> ident == ID_LINE);
   // R11
   irq_code_chk: assert property (@(posedge clk) disable iff (rst)
      irq == (ident != ID_NONE));
endmodule

// File: tb/uart_regfile_irq_test.sv
module uart_regfile_irq_test;
   localparam int ADDR_W = 6;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_data = '0;
   logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
   logic              rx_ready, tx_valid;
   logic [7:0]        tx_data;
   logic              tx_ready = 1'b0;
   logic [3:0]        modem_lines = '0, modem_delta = '0;
   logic [7:0]        lcr_out, mcr_out;
   logic [15:0]       div_out;
   logic              irq;

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_regfile_irq uut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
      .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .modem_lines(modem_lines), .modem_delta(modem_delta),
      .lcr_out(lcr_out), .mcr_out(mcr_out), .div_out(div_out), .irq(irq)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic brd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic rxb(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
   endtask

   function automatic logic [2:0] exp_id(input logic [3:0] ie, input bit e,
                                        input bit d, input bit m);
      if (e && ie[2]) return 3'b110;
      if (d && ie[0]) return 3'b100;
      if (ie[1])      return 3'b010;
      if (m && ie[3]) return 3'b000;
      return 3'b001;
   endfunction

   localparam logic [ADDR_W-1:0] A_DATA = 6'h00, A_IEN = 6'h04, A_ID = 6'h08,
      A_LCR = 6'h0C, A_MCR = 6'h10, A_LSR = 6'h14, A_MSR = 6'h18, A_DIV = 6'h1C;

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 rx_ready", {31'd0, rx_ready}, 1);
      chk("R1 tx_valid", {31'd0, tx_valid}, 0);
      chk("R1 lcr", {24'd0, lcr_out}, 0);
      chk("R1 div", {16'd0, div_out}, 0);
      brd(A_LSR, v); chk("R1 lsr", v, 32'h60);
      brd(A_ID, v);  chk("R1 ident", v, 32'h01);

      // R2 write-only registers
      bwr(A_LCR, 32'hFFFF_FF1B);
      bwr(A_MCR, 32'h0000_0003);
      bwr(A_DIV, 32'hABCD_1234);
      chk("R2 lcr_out", {24'd0, lcr_out}, 32'h1B);
      chk("R2 mcr_out", {24'd0, mcr_out}, 32'h03);
      chk("R2 div_out", {16'd0, div_out}, 32'h1234);
      brd(A_LCR, v); chk("R2 lcr read", v, 0);
      brd(A_MCR, v); chk("R2 mcr read", v, 0);
      brd(A_DIV, v); chk("R2 div read", v, 0);
      brd(A_IEN, v); chk("R2 ien read", v, 0);

      // R3 read-only and out-of-window accesses
      bwr(A_LSR, 32'hFF);
      bwr(A_ID, 32'hFF);
      brd(A_LSR, v); chk("R3 lsr write ignored", v, 32'h60);
      brd(A_ID, v);  chk("R3 ident write ignored", v, 32'h01);
      bwr(6'h2C, 32'h55);
      chk("R3 oow lcr alias", {24'd0, lcr_out}, 32'h1B);
      bwr(6'h20, 32'h77);
      chk("R3 oow data alias", {31'd0, tx_valid}, 0);
      brd(6'h34, v); chk("R3 oow read", v, 0);

      // R4 R6 receive and read
      rxb(8'h5A, 0, 0, 0);
      chk("R4 rx_ready low", {31'd0, rx_ready}, 0);
      brd(A_LSR, v); chk("R4 data ready", v, 32'h61);
      brd(A_DATA, v); chk("R6 held byte", v, 32'h5A);
      chk("R6 rx_ready back", {31'd0, rx_ready}, 1);
      brd(A_LSR, v); chk("R6 data ready cleared", v, 32'h60);

      // R5 overrun
      rxb(8'h11, 0, 0, 0);
      rxb(8'h22, 0, 0, 0);
      brd(A_LSR, v); chk("R5 overrun", v, 32'h63);
      brd(A_DATA, v); chk("R5 newest byte", v, 32'h22);
      brd(A_LSR, v); chk("R5 cleared", v, 32'h60);

      // R8 error flags and read-clear
      rxb(8'h33, 1, 1, 1);
      brd(A_LSR, v); chk("R8 err flags", v, 32'h7D);
      brd(A_LSR, v); chk("R8 read clears", v, 32'h61);
      brd(A_DATA, v);

      // R9 modem status
      modem_lines = 4'hA;
      @(negedge clk); modem_delta = 4'b0101;
      @(negedge clk); modem_delta = 4'b0000;
      brd(A_MSR, v); chk("R9 msr", v, 32'hA5);
      brd(A_MSR, v); chk("R9 msr cleared", v, 32'hA0);

      // R7 transmit handoff
      bwr(A_DATA, 32'h1A5);
      chk("R7 tx_valid", {31'd0, tx_valid}, 1);
      chk("R7 tx_data", {24'd0, tx_data}, 32'hA5);
      bwr(A_DATA, 32'h3C);
      chk("R7 busy drop", {24'd0, tx_data}, 32'hA5);
      brd(A_LSR, v); chk("R7 empty flags", v, 32'h60);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      chk("R7 accepted", {31'd0, tx_valid}, 0);
      bwr(A_DATA, 32'h3C);
      chk("R7 next byte", {24'd0, tx_data}, 32'h3C);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;

      // R10 R11 sweep over enables and sources
      for (int ie = 0; ie < 16; ie++) begin
         for (int s = 0; s < 8; s++) begin
            bit e, d, m;
            e = s[0]; d = s[1]; m = s[2];
            brd(A_DATA, v); brd(A_LSR, v); brd(A_MSR, v);
            if (e) begin
               rxb(8'hE0, 1, 0, 0);
               if (!d) brd(A_DATA, v);
            end else if (d) begin
               rxb(8'hD0, 0, 0, 0);
            end
            if (m) begin
               @(negedge clk); modem_delta = 4'b1000;
               @(negedge clk); modem_delta = 4'b0000;
            end
            bwr(A_IEN, ie);
            brd(A_ID, v);
            chk($sformatf("R10 ident ie=%0d s=%0d", ie, s), v,
                {29'd0, exp_id(ie[3:0], e, d, m)});
            chk($sformatf("R11 irq ie=%0d s=%0d", ie, s), {31'd0, irq},
                {31'd0, exp_id(ie[3:0], e, d, m) != 3'b001});
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule